// File: doc/BRIEF.md
# Dual-Buffer Frame Receiver with Destination Filter

This block accepts an incoming Ethernet-style frame as a byte stream and stores each frame it accepts into one of two receive buffers that a host reads through a word-addressed port. The first six bytes of a frame carry its destination. A frame whose first byte has its top bit set is a group frame and is always taken. Any other frame is taken only when all six destination bytes equal the station address. A frame is also refused when the buffer it would land in still holds a frame the host has not released.

When a frame has been stored completely, the buffer's full flag is set. If that buffer's interrupt enable and the global enable are both on, a single-cycle interrupt pulse follows. With alternation switched on, the receiver swaps to the other buffer after each stored frame; with it off, every frame goes to buffer 0. The host releases a buffer by clearing its full flag. The stream input never applies backpressure: a refused frame is read in up to its last byte and thrown away.

Top module: `rxPingPongFilter`

## Requirements
- R1: After reset both control words read 0, the global enable reads 0, irq and dropPulse are low, and the next frame goes to buffer 0.
- R2: Host map (word addresses, BUF_AW=9): buffer b data words at b*512+0..510, buffer b control at b*512+511, global enable at 1024. Byte k of a stored frame sits in data word k/4, bits 8*(k%4)+7..8*(k%4). hostRdata shows the addressed word one cycle after hostAddr is presented.
- R3: A frame whose first byte has bit 7 clear is stored only if bytes 0..5 equal stationAddr[47:40], [39:32], ..., [7:0] in that order. Any mismatch leaves both full flags, the buffer choice and irq unchanged.
- R4: A frame whose first byte has bit 7 set is stored whatever its destination bytes are.
- R5: If the selected buffer's full flag (control bit 0) is set when a frame starts, none of its bytes are written. Full flags, buffer choice and irq are unchanged, and dropPulse is high for one cycle right after the frame's last beat.
- R6: After a stored frame's last beat, control bit 0 of that buffer reads 1.
- R7: irq pulses for exactly one cycle right after a stored frame's last beat, if and only if that buffer's control bit 3 and global-enable bit 31 are both 1.
- R8: With pingPongEn high, each stored frame moves the selection to the other buffer. With it low, frames always go to buffer 0, and buffer 0 is also selected after the frame is stored.
- R9: A host write to a control word loads bit 0 (full) and bit 3 (interrupt enable) from hostWdata. Writing bit 0 as 0 frees the buffer for the next frame. A host write to the global enable loads bit 31.
- R10: Bytes beyond the 2044-byte data area are discarded. The frame is still marked full and signalled.
- R11: A frame that ends before its sixth byte is not stored.
- R12: rxTready is 1 at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxTvalid | input | 1 | Stream byte valid |
| rxTdata | input | 8 | Stream byte |
| rxTlast | input | 1 | Last byte of frame |
| rxTready | output | 1 | Always ready |
| stationAddr | input | 48 | Station address, first byte in bits 47:40 |
| pingPongEn | input | 1 | Alternate between the two buffers |
| hostAddr | input | BUF_AW+2 | Host word address |
| hostWe | input | 1 | Host write strobe |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Registered host read data |
| irq | output | 1 | Frame-stored interrupt pulse |
| dropPulse | output | 1 | Pulse after a frame refused for a full buffer |

## Verification
The assertions assume that pingPongEn and stationAddr are held steady while a frame is in flight. They also assume that the host does not rewrite the control word of the buffer being filled during that frame, since the drop decision is taken at the frame's first byte. The stimulus changes those inputs only between frames, after the last beat has been taken. Frame lengths sweep the lane positions of the final word, and mismatches are placed at each of the six destination positions.

// File: rtl/rxPingPongPkg.sv
package rxPingPongPkg;
  typedef struct packed {
    logic        wrEn;
    logic        wrBuf;
    logic [15:0] wrByte;
    logic [7:0]  wrData;
    logic        commit;
    logic        commitBuf;
  } rxStrobes_t;
endpackage

// File: rtl/rxFrameCtrl.sv
module rxFrameCtrl
  import rxPingPongPkg::*;
#(
  parameter int BUF_AW = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxTvalid,
  input  logic [7:0]  rxTdata,
  input  logic        rxTlast,
  input  logic [47:0] stationAddr,
  input  logic        pingPongEn,
  input  logic [1:0]  bufFull,
  output rxStrobes_t  strobes,
  output logic        dropPulse
);
  localparam int DATA_BYTES = ((1 << BUF_AW) - 1) * 4;
  localparam int CNT_W = BUF_AW + 3;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DATA_BYTES);

  logic [CNT_W-1:0] byteCnt;
  logic matchQ, groupQ, rejectQ, dropQ, tgtQ;
  logic first, curTgt, dropNow, grpNow, inHdr, matchNow, okNow, rejectNow;
  logic [7:0] stationByte;

  always_comb begin
    case (byteCnt[2:0])
      3'd0: stationByte = stationAddr[47:40];
      3'd1: stationByte = stationAddr[39:32];
      3'd2: stationByte = stationAddr[31:24];
      3'd3: stationByte = stationAddr[23:16];
      3'd4: stationByte = stationAddr[15:8];
      default: stationByte = stationAddr[7:0];
    endcase
  end

  always_comb begin
    first    = (byteCnt == '0);
    curTgt   = pingPongEn ? tgtQ : 1'b0;
    dropNow  = first ? bufFull[curTgt] : dropQ;
    grpNow   = first ? rxTdata[7] : groupQ;
    inHdr    = (byteCnt < CNT_W'(6));
    matchNow = (first ? 1'b1 : matchQ) && (!inHdr || (rxTdata == stationByte));
    okNow    = grpNow || matchNow;
    if (byteCnt < CNT_W'(5))       rejectNow = 1'b0;
    else if (byteCnt == CNT_W'(5)) rejectNow = !okNow;
    else                           rejectNow = rejectQ;
  end

  always_comb begin
    strobes.wrEn      = rxTvalid && !dropNow && !rejectNow && (byteCnt < CNT_END);
    strobes.wrBuf     = curTgt;
    strobes.wrByte    = 16'(byteCnt);
    strobes.wrData    = rxTdata;
    strobes.commit    = rxTvalid && rxTlast && !dropNow && !rejectNow &&
                        (byteCnt >= CNT_W'(5));
    strobes.commitBuf = curTgt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt   <= '0;
      matchQ    <= 1'b0;
      groupQ    <= 1'b0;
      rejectQ   <= 1'b0;
      dropQ     <= 1'b0;
      tgtQ      <= 1'b0;
      dropPulse <= 1'b0;
    end else begin
      dropPulse <= rxTvalid && rxTlast && dropNow;
      if (rxTvalid) begin
        matchQ  <= matchNow;
        groupQ  <= grpNow;
        rejectQ <= rejectNow;
        dropQ   <= dropNow;
        if (rxTlast)                byteCnt <= '0;
        else if (byteCnt != CNT_END) byteCnt <= byteCnt + 1'b1;
      end
      if (strobes.commit) tgtQ <= pingPongEn ? ~curTgt : 1'b0;
    end
  end

  assert_no_write_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> !bufFull[strobes.wrBuf]);
  assert_commit_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> !bufFull[strobes.commitBuf]);
  assert_fixed_buffer_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !pingPongEn) |-> !strobes.commitBuf);
  assert_write_in_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> (strobes.wrByte < 16'(DATA_BYTES)));
endmodule

// File: rtl/rxBufDatapath.sv
module rxBufDatapath
  import rxPingPongPkg::*;
#(
  parameter int BUF_AW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic [BUF_AW+1:0] hostAddr,
  input  logic              hostWe,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic [1:0]        bufFull,
  output logic              irq
);
  localparam int BUF_WORDS = 1 << BUF_AW;
  localparam int MEM_WORDS = 2 * BUF_WORDS;

  logic [31:0] mem [MEM_WORDS];
  logic [1:0]  fullQ, intEnQ;
  logic        gieQ;

  logic              isGie, hostBuf, isCtrl;
  logic [BUF_AW-1:0] hostWord;
  logic [BUF_AW-1:0] wrWord;
  logic [1:0]        wrLane;

  assign isGie    = hostAddr[BUF_AW+1];
  assign hostBuf  = hostAddr[BUF_AW];
  assign hostWord = hostAddr[BUF_AW-1:0];
  assign isCtrl   = !isGie && (&hostWord);
  assign wrWord   = strobes.wrByte[BUF_AW+1:2];
  assign wrLane   = strobes.wrByte[1:0];
  assign bufFull  = fullQ;

  always_ff @(posedge clk) begin
    if (strobes.wrEn)
      mem[{strobes.wrBuf, wrWord}][{wrLane, 3'b000} +: 8] <= strobes.wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ     <= '0;
      intEnQ    <= '0;
      gieQ      <= 1'b0;
      irq       <= 1'b0;
      hostRdata <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (hostWe && isCtrl && (hostBuf == 1'(b))) begin
          fullQ[b]  <= hostWdata[0];
          intEnQ[b] <= hostWdata[3];
        end
        if (strobes.commit && (strobes.commitBuf == 1'(b)))
          fullQ[b] <= 1'b1;
      end
      if (hostWe && isGie) gieQ <= hostWdata[31];
      irq <= strobes.commit && intEnQ[strobes.commitBuf] && gieQ;
      if (isGie)       hostRdata <= {gieQ, 31'b0};
      else if (isCtrl) hostRdata <= {28'b0, intEnQ[hostBuf], 2'b00, fullQ[hostBuf]};
      else             hostRdata <= mem[{hostBuf, hostWord}];
    end
  end

  assert_set_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> fullQ[$past(strobes.commitBuf)]);
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(strobes.commit && gieQ));
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
endmodule

// File: rtl/rxPingPongFilter.sv
module rxPingPongFilter
  import rxPingPongPkg::*;
#(
  parameter int BUF_AW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxTvalid,
  input  logic [7:0]        rxTdata,
  input  logic              rxTlast,
  output logic              rxTready,
  input  logic [47:0]       stationAddr,
  input  logic              pingPongEn,
  input  logic [BUF_AW+1:0] hostAddr,
  input  logic              hostWe,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              irq,
  output logic              dropPulse
);
  rxStrobes_t strobes;
  logic [1:0] bufFull;

  assign rxTready = 1'b1;

  rxFrameCtrl #(.BUF_AW(BUF_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .rxTvalid(rxTvalid), .rxTdata(rxTdata),
    .rxTlast(rxTlast), .stationAddr(stationAddr), .pingPongEn(pingPongEn),
    .bufFull(bufFull), .strobes(strobes), .dropPulse(dropPulse)
  );

  rxBufDatapath #(.BUF_AW(BUF_AW)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostAddr(hostAddr),
    .hostWe(hostWe), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .bufFull(bufFull), .irq(irq)
  );
endmodule

// File: tb/tb_rxPingPongFilter.sv
module tb_rxPingPongFilter;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_AW = 9;
  localparam int DATA_BYTES = ((1 << BUF_AW) - 1) * 4;
  localparam int GIE_ADDR = 1024;
  localparam logic [47:0] STATION = 48'h02_1A_2B_3C_4D_5E;

  logic clk = 0, rstN = 0;
  logic rxTvalid = 0, rxTlast = 0, pingPongEn = 0, hostWe = 0;
  logic [7:0] rxTdata = 0;
  logic [BUF_AW+1:0] hostAddr = 0;
  logic [31:0] hostWdata = 0;
  logic rxTready, irq, dropPulse;
  logic [31:0] hostRdata;

  int checks = 0, errors = 0, irqCount = 0, dropCount = 0, expTgt = 0;
  logic [7:0] frm [0:DATA_BYTES+63];

  rxPingPongFilter #(.BUF_AW(BUF_AW)) dut (
    .clk(clk), .rstN(rstN), .rxTvalid(rxTvalid), .rxTdata(rxTdata),
    .rxTlast(rxTlast), .rxTready(rxTready), .stationAddr(STATION),
    .pingPongEn(pingPongEn), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .irq(irq), .dropPulse(dropPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    if (irq) irqCount++;
    if (dropPulse) dropCount++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ctrlAddr(input int b);
    return b * 512 + 511;
  endfunction

  task automatic build(input int len, input int seed, input int kind, input int misPos);
    for (int k = 0; k < len; k++) begin
      frm[k] = 8'((seed * 29 + k * 13 + (k >> 4)) & 255);
      if (k < 6 && kind != 2) begin
        frm[k] = STATION[8*(5-k) +: 8];
        if (kind == 1 && k == misPos) frm[k] = frm[k] ^ 8'h01;
      end
      if (k == 0 && kind == 2) frm[k] = frm[k] | 8'h80;
    end
  endtask

  task automatic send(input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rxTvalid = 1; rxTdata = frm[k]; rxTlast = (k == len - 1);
      if (rxTready !== 1'b1) check(0, "R12 ready", 0, 1);
    end
    @(negedge clk);
    rxTvalid = 0; rxTlast = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic hostRd(input int a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = (BUF_AW+2)'(a);
    @(negedge clk);
    d = hostRdata;
  endtask

  task automatic hostWr(input int a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = (BUF_AW+2)'(a); hostWdata = d; hostWe = 1;
    @(negedge clk);
    hostWe = 0;
  endtask

  task automatic checkBuf(input int b, input int len, input string req);
    int n, bad, badAct, badExp;
    logic [31:0] d;
    n = (len < DATA_BYTES) ? len : DATA_BYTES;
    bad = 0; badAct = 0; badExp = 0;
    for (int w = 0; w * 4 < n; w++) begin
      hostRd(b * 512 + w, d);
      for (int l = 0; l < 4; l++)
        if (w * 4 + l < n && d[8*l +: 8] !== frm[w*4+l] && bad == 0) begin
          bad = 1; badAct = int'(d[8*l +: 8]); badExp = int'(frm[w*4+l]);
        end
    end
    check(bad == 0, req, badAct, badExp);
  endtask

  task automatic checkFull(input int b, input int exp, input string req);
    logic [31:0] d;
    hostRd(ctrlAddr(b), d);
    check(int'(d[0]) == exp, req, int'(d[0]), exp);
  endtask

  // store one frame to the expected buffer and verify it, then free it
  task automatic storeAndCheck(input int len, input int seed, input int kind, input bit irqOn,
                               input string req);
    int irq0;
    irq0 = irqCount;
    build(len, seed, kind, 0);
    send(len);
    checkFull(expTgt, 1, {req, " full set (R6)"});
    checkBuf(expTgt, len, {req, " contents (R2)"});
    check(irqCount - irq0 == (irqOn ? 1 : 0), {req, " irq (R7)"}, irqCount - irq0, irqOn ? 1 : 0);
    hostWr(ctrlAddr(expTgt), 32'h8);
    expTgt = pingPongEn ? 1 - expTgt : 0;
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    int irq0, drop0;
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1 reset state
    hostRd(ctrlAddr(0), d); check(d == 0, "R1 ctrl0", int'(d), 0);
    hostRd(ctrlAddr(1), d); check(d == 0, "R1 ctrl1", int'(d), 0);
    hostRd(GIE_ADDR, d);    check(d == 0, "R1 gie", int'(d), 0);
    check(irq == 0 && dropPulse == 0, "R1 outputs", int'(irq), 0);
    check(rxTready == 1, "R12 ready", int'(rxTready), 1);
    // R9 enables
    hostWr(GIE_ADDR, 32'h8000_0000);
    hostRd(GIE_ADDR, d); check(d == 32'h8000_0000, "R9 gie", int'(d[31]), 1);
    hostWr(ctrlAddr(0), 32'h8); hostWr(ctrlAddr(1), 32'h8);
    hostRd(ctrlAddr(1), d); check(d == 32'h8, "R9 ctrl", int'(d), 8);
    pingPongEn = 1;
    // R3/R8 length sweep of matching frames, alternating buffers
    for (int len = 6; len < 18; len++) storeAndCheck(len, len, 0, 1, "R3 match sweep");
    for (int len = 61; len < 66; len++) storeAndCheck(len, len, 0, 1, "R8 pingpong sweep");
    // R3 mismatch at every destination position
    for (int p = 0; p < 6; p++) begin
      irq0 = irqCount;
      build(20, p, 1, p);
      send(20);
      checkFull(0, 0, "R3 reject buf0");
      checkFull(1, 0, "R3 reject buf1");
      check(irqCount == irq0, "R3 reject irq", irqCount - irq0, 0);
    end
    storeAndCheck(12, 77, 0, 1, "R3 index unchanged after reject");
    // R4 group bypass
    storeAndCheck(30, 5, 2, 1, "R4 group");
    storeAndCheck(7, 9, 2, 1, "R4 group short");
    // R11 short frames
    for (int len = 1; len < 6; len++) begin
      irq0 = irqCount;
      build(len, len, (len % 2 == 1) ? 2 : 0, 0);
      send(len);
      checkFull(0, 0, "R11 short buf0");
      checkFull(1, 0, "R11 short buf1");
      check(irqCount == irq0, "R11 short irq", irqCount - irq0, 0);
    end
    storeAndCheck(9, 3, 0, 1, "R11 index unchanged after short");
    // R5 drop when full
    irq0 = irqCount;
    build(40, 101, 0, 0); send(40);
    build(40, 102, 0, 0); send(40);
    drop0 = dropCount;
    build(40, 103, 0, 0); send(40);
    check(dropCount - drop0 == 1, "R5 drop pulse", dropCount - drop0, 1);
    check(irqCount - irq0 == 2, "R5 no irq on drop", irqCount - irq0, 2);
    build(40, 101, 0, 0);
    checkBuf(expTgt, 40, "R5 target untouched");
    checkFull(expTgt, 1, "R5 still full");
    hostWr(ctrlAddr(expTgt), 32'h8);
    storeAndCheck(33, 104, 0, 1, "R5 after free");
    checkFull(expTgt, 1, "R9 other still full");
    hostWr(ctrlAddr(expTgt), 32'h8);
    checkFull(expTgt, 0, "R9 freed");
    // R7 gating
    hostWr(ctrlAddr(expTgt), 32'h0);
    storeAndCheck(16, 55, 0, 0, "R7 int disabled");
    hostWr(ctrlAddr(1 - expTgt), 32'h8);
    hostWr(GIE_ADDR, 32'h0);
    storeAndCheck(16, 56, 0, 0, "R7 gie off");
    hostWr(GIE_ADDR, 32'h8000_0000);
    // R8 fixed buffer
    pingPongEn = 0; expTgt = 0;
    hostWr(ctrlAddr(0), 32'h8); hostWr(ctrlAddr(1), 32'h8);
    for (int i = 0; i < 3; i++) begin
      storeAndCheck(10 + i, 60 + i, 0, 1, "R8 fixed buf0");
      checkFull(1, 0, "R8 buf1 unused");
    end
    pingPongEn = 1; expTgt = 0;
    // R10 truncation
    storeAndCheck(DATA_BYTES + 10, 88, 0, 1, "R10 truncation");
    storeAndCheck(DATA_BYTES, 89, 0, 1, "R10 exact fill");
    finishRun();
  end
endmodule